// File: doc/BRIEF.md
# Two-Way Cache Protocol Checker

This block is a passive monitor placed beside the controller of a two-way set-associative cache. It watches the CPU's read and write request strobes, the replacement-way hint from the tag array, the read and write enables of both data ways and of the tag RAM, the main-memory read strobe and the data-valid strobe returned to the CPU. It drives nothing back into the cache. It records every protocol violation in a sticky flag and counts read hits and misses.

Each request leaves an obligation that is judged on the cycle after it. A four-state obligation register holds that obligation: CHK_IDLE (nothing pending), CHK_WR_WAY0 and CHK_WR_WAY1 (a write is pending, and the way it must use was fixed when the write was requested), and CHK_RD (a read is pending). The register is updated on every clock edge by one of five transitions. T_COLLIDE goes to CHK_IDLE when a read and a write arrive together. T_RD goes to CHK_RD. T_WR0 and T_WR1 go to the write states according to the hint. T_NONE goes to CHK_IDLE when there is no request. The transition depends only on the current request, so a new request can arrive on every cycle while the previous one is being judged.

Top module: `twoway_cache_monitor`

## Requirements
- R1: On the cycle after a write request (with no read), `evict_hint`=0 requires `way0_wr`=1 and `way1_wr`=0, and `evict_hint`=1 requires `way1_wr`=1 and `way0_wr`=0. Any other pair of enables sets `err_wr_excl`, visible after the edge that ends that following cycle.
- R2: In a cycle with a read request and no write request, `way0_rd`, `way1_rd` and `tag_rd` must all be 1. Otherwise `err_rd_strobe` is set, visible after the edge that ends that cycle.
- R3: On the cycle after a read request, `mem_rd` or `cpu_data_vld` must be 1. Otherwise `err_rd_latency` is set.
- R4: A read whose following cycle has `cpu_data_vld`=1 adds one to `hit_count`. Any other read adds one to `miss_count`. Both counts appear after the edge that ends the following cycle.
- R5: Both counters are CNT_W bits wide and wrap modulo 2^CNT_W.
- R6: A cycle with both a read and a write request sets `err_collision`. It creates no obligation, skips the read-strobe check and changes no counter.
- R7: Reset clears every flag and both counters. After that, each flag stays at 1 until the next reset.
- R8: Requests on consecutive cycles are each judged on their own following cycle, with no lost or merged checks.
- R9: The hint is taken in the cycle of the write request. Its value during the checked cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd_req | input | 1 | CPU read request |
| cpu_wr_req | input | 1 | CPU write request |
| evict_hint | input | 1 | Replacement way: 0 selects way 0, 1 selects way 1 |
| way0_rd | input | 1 | Way 0 read enable |
| way0_wr | input | 1 | Way 0 write enable |
| way1_rd | input | 1 | Way 1 read enable |
| way1_wr | input | 1 | Way 1 write enable |
| tag_rd | input | 1 | Tag RAM read enable |
| mem_rd | input | 1 | Main-memory read strobe |
| cpu_data_vld | input | 1 | Data valid returned to CPU |
| err_wr_excl | output | 1 | Sticky: write exclusivity violated |
| err_rd_strobe | output | 1 | Sticky: read strobes missing |
| err_rd_latency | output | 1 | Sticky: read neither missed nor returned |
| err_collision | output | 1 | Sticky: read and write requested together |
| hit_count | output | CNT_W | Read hits, wrapping |
| miss_count | output | CNT_W | Read misses, wrapping |

## Verification
Two functions can act in the same cycle. The next-cycle judgement of a pending request is made while a new request is being checked against the same-cycle rule and loaded as the next obligation. The bench provokes this by issuing reads on every cycle with a fixed hit/miss pattern, and by changing the hint in the cycle that checks a write. It then judges the final hit and miss counts and the untouched flags against values worked out by arithmetic on the pattern. A read arriving together with a write is also driven, and it must only raise the collision flag.

// File: rtl/cmon_pkg.sv
package cmon_pkg;
    typedef enum logic [1:0] {
        CHK_IDLE    = 2'd0,
        CHK_WR_WAY0 = 2'd1,
        CHK_WR_WAY1 = 2'd2,
        CHK_RD      = 2'd3
    } chk_state_t;

    typedef struct packed {
        logic collision;
        logic rd_latency;
        logic rd_strobe;
        logic wr_excl;
    } viol_t;

    localparam int NUM_VIOL = $bits(viol_t);
endpackage

// File: rtl/cmon_obligation_fsm.sv
module cmon_obligation_fsm
    import cmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_req,
    input  logic       wr_req,
    input  logic       hint,
    output chk_state_t state
);
    chk_state_t state_nxt;

    // Transition selection: T_COLLIDE, T_RD, T_WR0, T_WR1, T_NONE
    always_comb begin
        if (rd_req && wr_req)
            state_nxt = CHK_IDLE;
        else if (rd_req)
            state_nxt = CHK_RD;
        else if (wr_req)
            state_nxt = hint ? CHK_WR_WAY1 : CHK_WR_WAY0;
        else
            state_nxt = CHK_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= CHK_IDLE;
        else
            state <= state_nxt;
    end

    a_r1_write_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CHK_WR_WAY0 || state == CHK_WR_WAY1) |-> $past(wr_req && !rd_req));

    a_r9_hint_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CHK_WR_WAY1) |-> $past(hint));

    a_r6_collide_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && wr_req) |-> (state == CHK_IDLE));
endmodule

// File: rtl/cmon_rule_eval.sv
module cmon_rule_eval
    import cmon_pkg::*;
(
    input  chk_state_t state,
    input  logic       rd_req,
    input  logic       wr_req,
    input  logic       w0_rd,
    input  logic       w0_wr,
    input  logic       w1_rd,
    input  logic       w1_wr,
    input  logic       t_rd,
    input  logic       m_rd,
    input  logic       d_vld,
    output viol_t      viol,
    output logic       rd_hit,
    output logic       rd_miss
);
    logic all_read;

    always_comb begin
        all_read = w0_rd & w1_rd & t_rd;
        viol = '0;
        rd_hit = 1'b0;
        rd_miss = 1'b0;

        // same-cycle rules
        viol.collision = rd_req & wr_req;
        viol.rd_strobe = rd_req & ~wr_req & ~all_read;

        // next-cycle rules chosen by the pending obligation
        unique case (state)
            CHK_IDLE: ;
            CHK_WR_WAY0: viol.wr_excl = ~(w0_wr & ~w1_wr);
            CHK_WR_WAY1: viol.wr_excl = ~(w1_wr & ~w0_wr);
            CHK_RD: begin
                viol.rd_latency = ~(m_rd | d_vld);
                rd_hit  = d_vld;
                rd_miss = ~d_vld;
            end
        endcase
    end

    always_comb begin
        a_r4_one_outcome: assert ($onehot0({rd_hit, rd_miss}));
    end
endmodule

// File: rtl/cmon_sticky_flags.sv
module cmon_sticky_flags #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (set[g])
                flags[g] <= 1'b1;
        end

        a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            $past(flags[g]) |-> flags[g]);
    end
endmodule

// File: rtl/cmon_wrap_counter.sv
module cmon_wrap_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (inc)
            count <= count + ONE;
    end

    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> (count == $past(count) + ONE));
endmodule

// File: rtl/twoway_cache_monitor.sv
module twoway_cache_monitor
    import cmon_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_rd_req,
    input  logic             cpu_wr_req,
    input  logic             evict_hint,
    input  logic             way0_rd,
    input  logic             way0_wr,
    input  logic             way1_rd,
    input  logic             way1_wr,
    input  logic             tag_rd,
    input  logic             mem_rd,
    input  logic             cpu_data_vld,
    output logic             err_wr_excl,
    output logic             err_rd_strobe,
    output logic             err_rd_latency,
    output logic             err_collision,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int NUM_CNT = 2;

    chk_state_t          state;
    viol_t               viol;
    viol_t               flags;
    logic                rd_hit;
    logic                rd_miss;
    logic [NUM_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]    cnt_val [NUM_CNT];

    cmon_obligation_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (cpu_rd_req),
        .wr_req (cpu_wr_req),
        .hint   (evict_hint),
        .state  (state)
    );

    cmon_rule_eval u_eval (
        .state   (state),
        .rd_req  (cpu_rd_req),
        .wr_req  (cpu_wr_req),
        .w0_rd   (way0_rd),
        .w0_wr   (way0_wr),
        .w1_rd   (way1_rd),
        .w1_wr   (way1_wr),
        .t_rd    (tag_rd),
        .m_rd    (mem_rd),
        .d_vld   (cpu_data_vld),
        .viol    (viol),
        .rd_hit  (rd_hit),
        .rd_miss (rd_miss)
    );

    cmon_sticky_flags #(.N(NUM_VIOL)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (viol),
        .flags (flags)
    );

    assign cnt_inc = {rd_miss, rd_hit};

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
        cmon_wrap_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[c]),
            .count (cnt_val[c])
        );
    end

    assign hit_count      = cnt_val[0];
    assign miss_count     = cnt_val[1];
    assign err_wr_excl    = flags.wr_excl;
    assign err_rd_strobe  = flags.rd_strobe;
    assign err_rd_latency = flags.rd_latency;
    assign err_collision  = flags.collision;

    a_r4_hit_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> ($past(state) == CHK_RD && $past(cpu_data_vld)));

    a_r4_miss_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_count != $past(miss_count)) |-> ($past(state) == CHK_RD && !$past(cpu_data_vld)));

    a_r8_single_count: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_count != $past(hit_count)) |-> (miss_count == $past(miss_count)));

    a_r3_latency_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_rd_latency) |-> ($past(state) == CHK_RD && !$past(mem_rd) && !$past(cpu_data_vld)));
endmodule

// File: tb/twoway_cache_monitor_tb_top.sv
`timescale 1ns/1ps
module twoway_cache_monitor_tb_top;
    localparam int CNT_W = 4;
    localparam int MOD = 1 << CNT_W;

    logic clk = 1'b0;
    logic rst_n;
    logic rd_req, wr_req, hint, w0r, w0w, w1r, w1w, trd, mrd, vld;
    logic e_wr, e_rs, e_lat, e_col;
    logic [CNT_W-1:0] hits, misses;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twoway_cache_monitor #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_rd_req(rd_req), .cpu_wr_req(wr_req),
        .evict_hint(hint), .way0_rd(w0r), .way0_wr(w0w), .way1_rd(w1r),
        .way1_wr(w1w), .tag_rd(trd), .mem_rd(mrd), .cpu_data_vld(vld),
        .err_wr_excl(e_wr), .err_rd_strobe(e_rs), .err_rd_latency(e_lat),
        .err_collision(e_col), .hit_count(hits), .miss_count(misses)
    );

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        {rd_req, wr_req, hint, w0r, w0w, w1r, w1w, trd, mrd, vld} = '0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // n reads back to back; bit i of pat is the data-valid answer to read i
    task automatic run_reads(input int n, input logic [31:0] pat);
        for (int i = 0; i < n; i++) begin
            rd_req = 1'b1; w0r = 1'b1; w1r = 1'b1; trd = 1'b1;
            vld = (i > 0) ? pat[i-1] : 1'b0;
            mrd = (i > 0) ? ~pat[i-1] : 1'b0;
            step();
        end
        idle_inputs();
        vld = pat[n-1];
        mrd = ~pat[n-1];
        step();
        idle_inputs();
    endtask

    initial begin
        do_reset();
        // R7: reset state
        check("R7 reset flags", {e_wr, e_rs, e_lat, e_col}, 0);
        check("R7 reset hits", hits, 0);
        check("R7 reset misses", misses, 0);

        // R1: every hint and write-enable pair
        for (int h = 0; h < 2; h++) begin
            for (int s = 0; s < 4; s++) begin
                int exp_err;
                do_reset();
                wr_req = 1'b1; hint = h[0];
                step();
                idle_inputs();
                w0w = s[0]; w1w = s[1];
                step();
                idle_inputs();
                exp_err = (h == 0) ? ((s == 1) ? 0 : 1) : ((s == 2) ? 0 : 1);
                check("R1 write exclusivity", e_wr, exp_err);
                check("R1 no read flags", {e_rs, e_lat, e_col}, 0);
            end
        end

        // R9: hint changed in checked cycle is ignored
        for (int h = 0; h < 2; h++) begin
            do_reset();
            wr_req = 1'b1; hint = h[0];
            step();
            idle_inputs();
            hint = ~h[0];
            w0w = (h == 0); w1w = (h == 1);
            step();
            idle_inputs();
            check("R9 hint sampled at request", e_wr, 0);
        end

        // R2: all read-strobe combinations
        for (int s = 0; s < 8; s++) begin
            do_reset();
            rd_req = 1'b1; w0r = s[0]; w1r = s[1]; trd = s[2];
            step();
            idle_inputs();
            check("R2 read strobes", e_rs, (s == 7) ? 0 : 1);
            vld = 1'b1;
            step();
            idle_inputs();
            check("R2 no latency error", e_lat, 0);
        end

        // R3/R4: latency answers and hit/miss classification
        for (int s = 0; s < 4; s++) begin
            do_reset();
            rd_req = 1'b1; w0r = 1'b1; w1r = 1'b1; trd = 1'b1;
            step();
            idle_inputs();
            mrd = s[0]; vld = s[1];
            step();
            idle_inputs();
            check("R3 read latency", e_lat, (s == 0) ? 1 : 0);
            check("R4 hit count", hits, s[1]);
            check("R4 miss count", misses, s[1] ? 0 : 1);
        end

        // R6: collision
        do_reset();
        rd_req = 1'b1; wr_req = 1'b1;
        step();
        idle_inputs();
        check("R6 collision flag", e_col, 1);
        check("R6 strobe check skipped", e_rs, 0);
        step();
        check("R6 no obligation", {e_wr, e_lat}, 0);
        check("R6 no count", hits + misses, 0);
        // R7: flag stays set
        step();
        step();
        check("R7 sticky collision", e_col, 1);

        // R8: back-to-back reads with a mixed pattern
        do_reset();
        run_reads(10, 32'b10_1100_1110);
        check("R8 back-to-back hits", hits, 6);
        check("R8 back-to-back misses", misses, 4);
        check("R8 no flags", {e_wr, e_rs, e_lat, e_col}, 0);

        // R5: wrap of the hit counter
        do_reset();
        run_reads(18, 32'h3_FFFF);
        check("R5 hit wrap", hits, 18 % MOD);
        check("R5 miss untouched", misses, 0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule